// File: doc/BRIEF.md
# Hybrid PAL/PLA Product-Term Array

This block is the configurable logic core of a programmable logic cluster. It receives 36 signals from a global routing fabric and computes 16 data outputs for the downstream storage cells, plus six control outputs for their set/clear and drive-enable logic. Every product term can take any input in true form, in inverted form, or not at all. Each data output is the OR of five terms that belong only to it, together with any subset of a shared pool of 32 terms. The subset is picked through a programmable OR matrix, and one pool term can serve several outputs at once. Each of the six control terms can be set to act either as an AND or as an OR of its selected literals.

The configuration lives in internal registers. It is loaded one word per clock through a write-only address/data port. The array itself is purely combinational from the inputs and the stored configuration. A per-output flag goes high when that output draws on at least one pool term, which puts the output in the slower timing class.

Top module: `plapal_array`

## Requirements
- R1: After reset every stored mask, OR-matrix row and control mode is zero, so `data_out`, `ctl_out` and `pool_used` are all zero for any `in_bus`.
- R2: In a 72-bit term mask, bit i enables the true literal of input i and bit 36+i enables its inverted literal. A product term is the AND of its enabled literals. It is 0 when no literal is enabled, and it is 0 when both literals of the same input are enabled.
- R3: Addresses 0..79 hold the dedicated term masks, with term j of output o at address 5*o+j. Each data output is 1 whenever any of its five dedicated terms is 1.
- R4: Addresses 80..111 hold pool term p at 80+p. Addresses 118..149 hold OR-matrix row p at 118+p, where `cfg_wdata` bit o set routes pool term p to output o. One pool term may reach several outputs at the same time.
- R5: A single output combines up to 37 terms (5 dedicated plus all 32 pool terms), and any one of them alone drives the output to 1.
- R6: Addresses 112..117 hold control term c at 112+c. Address 150 holds the mode word: `cfg_wdata` bit c = 1 makes control term c a sum (OR of its enabled literals, 0 when none is enabled), and bit c = 0 makes it a product as in R2.
- R7: `pool_used[o]` is 1 exactly when some OR-matrix row has bit o set. Writes to term masks or to the mode word leave it unchanged.
- R8: Writes to addresses above 150 change nothing. Outputs follow `in_bus` in the same cycle, and a configuration write takes effect at the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration register clock |
| rst_n | input | 1 | Asynchronous active-low reset of all configuration |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 72 | Term mask, OR-matrix row (low 16 bits) or mode word (low 6 bits) |
| in_bus | input | 36 | Array inputs from the routing fabric |
| data_out | output | 16 | Sum-of-products data outputs |
| ctl_out | output | 6 | Control term outputs |
| pool_used | output | 16 | Per-output flag: output draws on the shared pool |

## Verification
On every cycle the assertions check three things. After a cycle with no effective write, the outputs stay constant as long as the inputs do. A written OR-matrix row raises the flags of all outputs it routes to. Writes to masks or to the mode word never disturb the flags. Only the bench's scenarios can show that the logic functions themselves are correct. Those scenarios cover literal polarity, the empty and contradictory product terms, the dedicated term addressing, pool sharing across outputs, the full 37-term output, and sum versus product control terms. All of these need expected values computed from the stored configuration.

// File: rtl/plapal_pkg.sv
`timescale 1ns/1ps
package plapal_pkg;

   typedef enum logic {
      TM_PRODUCT = 1'b0,
      TM_SUM     = 1'b1
   } term_mode_e;

   // address map: dedicated masks, pool masks, control masks, OR rows, mode word
   function automatic int f_pool_base(int n_out, int n_ded);
      return n_out * n_ded;
   endfunction

   function automatic int f_ctl_base(int n_out, int n_ded, int n_pool);
      return f_pool_base(n_out, n_ded) + n_pool;
   endfunction

   function automatic int f_row_base(int n_out, int n_ded, int n_pool, int n_ctl);
      return f_ctl_base(n_out, n_ded, n_pool) + n_ctl;
   endfunction

   function automatic int f_mode_addr(int n_out, int n_ded, int n_pool, int n_ctl);
      return f_row_base(n_out, n_ded, n_pool, n_ctl) + n_pool;
   endfunction

endpackage

// File: rtl/plapal_term.sv
`timescale 1ns/1ps
module plapal_term
   import plapal_pkg::*;
#(
   parameter int N_IN = 36,
   localparam int MW = 2 * N_IN
) (
   input  logic [MW-1:0]   mask,
   input  logic [N_IN-1:0] in_bus,
   input  term_mode_e      mode,
   output logic            hit
);

   logic [N_IN-1:0] true_en;
   logic [N_IN-1:0] comp_en;
   logic            any_lit;
   logic            prod_val;
   logic            sum_val;

   assign true_en  = mask[N_IN-1:0];
   assign comp_en  = mask[MW-1:N_IN];
   assign any_lit  = |mask;

   // a literal that is not enabled contributes 1 to the AND and 0 to the OR
   assign prod_val = any_lit & (&((~true_en | in_bus) & (~comp_en | ~in_bus)));
   assign sum_val  = |((true_en & in_bus) | (comp_en & ~in_bus));

   assign hit = (mode == TM_SUM) ? sum_val : prod_val;

endmodule

// File: rtl/plapal_cfg.sv
`timescale 1ns/1ps
module plapal_cfg
   import plapal_pkg::*;
#(
   parameter int N_IN   = 36,
   parameter int N_OUT  = 16,
   parameter int N_DED  = 5,
   parameter int N_POOL = 32,
   parameter int N_CTL  = 6,
   parameter int AW     = 8,
   localparam int MW    = 2 * N_IN,
   localparam int N_DT  = N_OUT * N_DED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [MW-1:0]    cfg_wdata,
   output logic [MW-1:0]    ded_mask [N_DT],
   output logic [MW-1:0]    pool_mask [N_POOL],
   output logic [MW-1:0]    ctl_mask [N_CTL],
   output logic [N_OUT-1:0] or_rows [N_POOL],
   output logic [N_CTL-1:0] ctl_mode
);

   localparam int PB = f_pool_base(N_OUT, N_DED);
   localparam int CB = f_ctl_base(N_OUT, N_DED, N_POOL);
   localparam int RB = f_row_base(N_OUT, N_DED, N_POOL, N_CTL);
   localparam int MA = f_mode_addr(N_OUT, N_DED, N_POOL, N_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_DT; k++)   ded_mask[k]  <= '0;
         for (int k = 0; k < N_POOL; k++) pool_mask[k] <= '0;
         for (int k = 0; k < N_CTL; k++)  ctl_mask[k]  <= '0;
         for (int k = 0; k < N_POOL; k++) or_rows[k]   <= '0;
         ctl_mode <= '0;
      end else if (cfg_we) begin
         for (int k = 0; k < N_DT; k++)
            if (cfg_addr == AW'(k)) ded_mask[k] <= cfg_wdata;
         for (int k = 0; k < N_POOL; k++)
            if (cfg_addr == AW'(PB + k)) pool_mask[k] <= cfg_wdata;
         for (int k = 0; k < N_CTL; k++)
            if (cfg_addr == AW'(CB + k)) ctl_mask[k] <= cfg_wdata;
         for (int k = 0; k < N_POOL; k++)
            if (cfg_addr == AW'(RB + k)) or_rows[k] <= cfg_wdata[N_OUT-1:0];
         if (cfg_addr == AW'(MA)) ctl_mode <= cfg_wdata[N_CTL-1:0];
      end
   end

endmodule

// File: rtl/plapal_or.sv
`timescale 1ns/1ps
module plapal_or #(
   parameter int N_OUT  = 16,
   parameter int N_DED  = 5,
   parameter int N_POOL = 32
) (
   input  logic [N_DED-1:0] ded_hit [N_OUT],
   input  logic [N_POOL-1:0] pool_hit,
   input  logic [N_OUT-1:0] or_rows [N_POOL],
   output logic [N_OUT-1:0] data_out,
   output logic [N_OUT-1:0] pool_used
);

   logic [N_POOL-1:0] column [N_OUT];

   for (genvar o = 0; o < N_OUT; o++) begin : g_col
      for (genvar p = 0; p < N_POOL; p++) begin : g_bit
         assign column[o][p] = or_rows[p][o];
      end
      assign pool_used[o] = |column[o];
      assign data_out[o]  = (|ded_hit[o]) | (|(column[o] & pool_hit));
   end

endmodule

// File: rtl/plapal_array.sv
`timescale 1ns/1ps
module plapal_array
   import plapal_pkg::*;
#(
   parameter int N_IN   = 36,
   parameter int N_OUT  = 16,
   parameter int N_DED  = 5,
   parameter int N_POOL = 32,
   parameter int N_CTL  = 6,
   parameter int AW     = $clog2(f_mode_addr(N_OUT, N_DED, N_POOL, N_CTL) + 1),
   localparam int MW    = 2 * N_IN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [MW-1:0]    cfg_wdata,
   input  logic [N_IN-1:0]  in_bus,
   output logic [N_OUT-1:0] data_out,
   output logic [N_CTL-1:0] ctl_out,
   output logic [N_OUT-1:0] pool_used
);

   localparam int N_DT = N_OUT * N_DED;
   localparam int MA   = f_mode_addr(N_OUT, N_DED, N_POOL, N_CTL);

   // elaboration-time parameter checks
   if (N_IN < 1 || N_OUT < 1 || N_DED < 1 || N_POOL < 1 || N_CTL < 1) begin : g_bad_size
      $error("plapal_array: every size parameter must be at least 1");
   end
   if (MW < N_OUT || MW < N_CTL) begin : g_bad_width
      $error("plapal_array: data word narrower than an OR row or the mode word");
   end
   if ((1 << AW) <= MA) begin : g_bad_addr
      $error("plapal_array: address width cannot reach the mode word");
   end

   logic [MW-1:0]     ded_mask  [N_DT];
   logic [MW-1:0]     pool_mask [N_POOL];
   logic [MW-1:0]     ctl_mask  [N_CTL];
   logic [N_OUT-1:0]  or_rows   [N_POOL];
   logic [N_CTL-1:0]  ctl_mode;
   logic [N_DED-1:0]  ded_hit   [N_OUT];
   logic [N_POOL-1:0] pool_hit;

   plapal_cfg #(
      .N_IN(N_IN), .N_OUT(N_OUT), .N_DED(N_DED),
      .N_POOL(N_POOL), .N_CTL(N_CTL), .AW(AW)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .ded_mask  (ded_mask),
      .pool_mask (pool_mask),
      .ctl_mask  (ctl_mask),
      .or_rows   (or_rows),
      .ctl_mode  (ctl_mode)
   );

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      for (genvar j = 0; j < N_DED; j++) begin : g_ded
         plapal_term #(.N_IN(N_IN)) u_term (
            .mask   (ded_mask[o*N_DED + j]),
            .in_bus (in_bus),
            .mode   (TM_PRODUCT),
            .hit    (ded_hit[o][j])
         );
      end
   end

   for (genvar p = 0; p < N_POOL; p++) begin : g_pool
      plapal_term #(.N_IN(N_IN)) u_term (
         .mask   (pool_mask[p]),
         .in_bus (in_bus),
         .mode   (TM_PRODUCT),
         .hit    (pool_hit[p])
      );
   end

   for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
      plapal_term #(.N_IN(N_IN)) u_term (
         .mask   (ctl_mask[c]),
         .in_bus (in_bus),
         .mode   (term_mode_e'(ctl_mode[c])),
         .hit    (ctl_out[c])
      );
   end

   plapal_or #(
      .N_OUT(N_OUT), .N_DED(N_DED), .N_POOL(N_POOL)
   ) u_or (
      .ded_hit   (ded_hit),
      .pool_hit  (pool_hit),
      .or_rows   (or_rows),
      .data_out  (data_out),
      .pool_used (pool_used)
   );

endmodule

// File: rtl/plapal_array_chk.sv
`timescale 1ns/1ps
module plapal_array_chk
   import plapal_pkg::*;
#(
   parameter int N_IN   = 36,
   parameter int N_OUT  = 16,
   parameter int N_DED  = 5,
   parameter int N_POOL = 32,
   parameter int N_CTL  = 6,
   parameter int AW     = 8,
   localparam int MW    = 2 * N_IN
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [AW-1:0]    cfg_addr,
   input logic [MW-1:0]    cfg_wdata,
   input logic [N_IN-1:0]  in_bus,
   input logic [N_OUT-1:0] data_out,
   input logic [N_CTL-1:0] ctl_out,
   input logic [N_OUT-1:0] pool_used
);

   localparam int RB = f_row_base(N_OUT, N_DED, N_POOL, N_CTL);
   localparam int MA = f_mode_addr(N_OUT, N_DED, N_POOL, N_CTL);

   AST_OUTPUTS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({data_out, ctl_out, pool_used})); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || cfg_addr > AW'(MA)) |=>
         ($stable(in_bus) |-> ($stable(data_out) && $stable(ctl_out) && $stable(pool_used)))); // R8

   AST_ROW_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr >= AW'(RB) && cfg_addr < AW'(MA)) |=>
         ((pool_used & $past(cfg_wdata[N_OUT-1:0])) == $past(cfg_wdata[N_OUT-1:0]))); // R7

   AST_MASK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_addr < AW'(RB) || cfg_addr == AW'(MA))) |=> $stable(pool_used)); // R7

endmodule

bind plapal_array plapal_array_chk #(
   .N_IN(N_IN), .N_OUT(N_OUT), .N_DED(N_DED),
   .N_POOL(N_POOL), .N_CTL(N_CTL), .AW(AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .in_bus    (in_bus),
   .data_out  (data_out),
   .ctl_out   (ctl_out),
   .pool_used (pool_used)
);

// File: tb/plapal_array_test.sv
`timescale 1ns/1ps
module plapal_array_test;

   localparam int NI = 36;
   localparam int NO = 16;
   localparam int ND = 5;
   localparam int NP = 32;
   localparam int NC = 6;
   localparam int MW = 72;
   localparam int A_POOL = 80;
   localparam int A_CTL  = 112;
   localparam int A_ROW  = 118;
   localparam int A_MODE = 150;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_addr = '0;
   logic [MW-1:0] cfg_wdata = '0;
   logic [NI-1:0] in_bus = '0;
   logic [NO-1:0] data_out;
   logic [NC-1:0] ctl_out;
   logic [NO-1:0] pool_used;

   int checks = 0;
   int errors = 0;

   logic [MW-1:0] m_ded  [NO*ND];
   logic [MW-1:0] m_pool [NP];
   logic [MW-1:0] m_ctl  [NC];
   logic [NO-1:0] m_row  [NP];
   logic [NC-1:0] m_mode;

   always #2.5 clk = ~clk;

   plapal_array uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_bus(in_bus), .data_out(data_out),
      .ctl_out(ctl_out), .pool_used(pool_used)
   );

   function automatic logic f_term(logic [MW-1:0] m, logic [NI-1:0] x, logic as_sum);
      logic [NI-1:0] t = m[NI-1:0];
      logic [NI-1:0] c = m[MW-1:NI];
      if (as_sum) return |((t & x) | (c & ~x));
      if (m == '0) return 1'b0;
      return ((t & ~x) == '0) && ((c & x) == '0);
   endfunction

   function automatic logic [NO-1:0] f_data(logic [NI-1:0] x);
      logic [NO-1:0] r = '0;
      for (int o = 0; o < NO; o++) begin
         for (int j = 0; j < ND; j++) r[o] |= f_term(m_ded[o*ND+j], x, 1'b0);
         for (int p = 0; p < NP; p++) r[o] |= m_row[p][o] & f_term(m_pool[p], x, 1'b0);
      end
      return r;
   endfunction

   function automatic logic [NC-1:0] f_ctl(logic [NI-1:0] x);
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) r[c] = f_term(m_ctl[c], x, m_mode[c]);
      return r;
   endfunction

   function automatic logic [NO-1:0] f_flags();
      logic [NO-1:0] r = '0;
      for (int p = 0; p < NP; p++) r |= m_row[p];
      return r;
   endfunction

   function automatic logic [MW-1:0] f_rand_mask(int nlit);
      logic [MW-1:0] m = '0;
      for (int k = 0; k < nlit; k++) m[$urandom % MW] = 1'b1;
      return m;
   endfunction

   task automatic model_clear();
      for (int k = 0; k < NO*ND; k++) m_ded[k] = '0;
      for (int k = 0; k < NP; k++) begin m_pool[k] = '0; m_row[k] = '0; end
      for (int k = 0; k < NC; k++) m_ctl[k] = '0;
      m_mode = '0;
   endtask

   task automatic check_all(input string req);
      logic [NO-1:0] ed = f_data(in_bus);
      logic [NC-1:0] ec = f_ctl(in_bus);
      logic [NO-1:0] ef = f_flags();
      checks += 3;
      if (data_out !== ed) begin
         errors++;
         $display("FAIL %s data_out in=%h got %h exp %h", req, in_bus, data_out, ed);
      end
      if (ctl_out !== ec) begin
         errors++;
         $display("FAIL %s ctl_out in=%h got %h exp %h", req, in_bus, ctl_out, ec);
      end
      if (pool_used !== ef) begin
         errors++;
         $display("FAIL %s pool_used got %h exp %h", req, pool_used, ef);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cfg_we = 1'b0;
      model_clear();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_write(input int addr, input logic [MW-1:0] data);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = addr[7:0];
      cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr < A_POOL)      m_ded[addr] = data;
      else if (addr < A_CTL)  m_pool[addr - A_POOL] = data;
      else if (addr < A_ROW)  m_ctl[addr - A_CTL] = data;
      else if (addr < A_MODE) m_row[addr - A_ROW] = data[NO-1:0];
      else if (addr == A_MODE) m_mode = data[NC-1:0];
   endtask

   task automatic drive_check(input logic [NI-1:0] v, input string req);
      @(negedge clk);
      in_bus = v;
      #1;
      check_all(req);
   endtask

   function automatic logic [MW-1:0] lit(int idx);
      logic [MW-1:0] m = '0;
      m[idx] = 1'b1;
      return m;
   endfunction

   initial begin
      #(5.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      do_reset();

      // R1: cleared configuration gives all-zero outputs
      drive_check('1, "R1");
      drive_check(36'h5A5A5A5A5, "R1");
      drive_check('0, "R1");

      // R2/R3: single true literal on input 3 in term 0 of output 0
      cfg_write(0, lit(3));
      drive_check(36'h8, "R2");
      drive_check(36'h0, "R2");
      // R2: inverted literal only
      cfg_write(0, lit(NI + 3));
      drive_check(36'h0, "R2");
      drive_check(36'h8, "R2");
      // R2: both literals of the same input never fire
      cfg_write(0, lit(3) | lit(NI + 3));
      drive_check(36'h8, "R2");
      drive_check(36'h0, "R2");
      cfg_write(0, '0);
      drive_check('1, "R2");

      // R3: last dedicated term of the last output (address 79)
      cfg_write(79, lit(0) | lit(NI + 1));
      drive_check(36'h1, "R3");
      drive_check(36'h3, "R3");

      // R4/R7: pool term 0 shared by outputs 2 and 9
      cfg_write(A_POOL + 0, lit(5));
      drive_check(36'h20, "R7");
      cfg_write(A_ROW + 0, 72'h0204);
      drive_check(36'h20, "R4");
      drive_check(36'h00, "R4");

      // R6: control term 0 as product, then sum, then empty sum
      cfg_write(A_CTL + 0, lit(1) | lit(2));
      drive_check(36'h2, "R6");
      drive_check(36'h6, "R6");
      cfg_write(A_MODE, 72'h1);
      drive_check(36'h2, "R6");
      drive_check(36'h0, "R6");
      cfg_write(A_CTL + 0, '0);
      drive_check('1, "R6");

      // R8: writes beyond the map are ignored
      cfg_write(200, '1);
      drive_check(36'h20, "R8");
      cfg_write(255, '1);
      drive_check(36'h0, "R8");

      // R5: output 7 built from all 37 terms, each one alone sets it
      do_reset();
      for (int j = 0; j < ND; j++) cfg_write(7*ND + j, lit(NP + (j % 4)));
      for (int p = 0; p < NP; p++) begin
         cfg_write(A_POOL + p, lit(p));
         cfg_write(A_ROW + p, 72'h80);
      end
      for (int k = 0; k < NI; k++) drive_check(36'h1 << k, "R5");
      drive_check('0, "R5");

      // random configurations and inputs
      for (int it = 0; it < 300; it++) begin
         if (it % 60 == 0) do_reset();
         for (int w = 0; w < 3; w++) begin
            int a = $urandom % 152;
            logic [MW-1:0] d;
            if (a >= A_ROW && a <= A_MODE) d = {$urandom, $urandom, $urandom};
            else d = f_rand_mask(1 + ($urandom % 2));
            cfg_write(a, d);
         end
         for (int v = 0; v < 3; v++)
            drive_check({$urandom, $urandom}, "R3/R4/R6/R7");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule